// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the protocol engine of a byte-addressed serial memory that sits on a two-wire bus as a slave. A fast system clock samples both bus lines. The block finds start and stop conditions and recognises its own bus address, which is a fixed four-bit identifier followed by three strap pins. For a write it takes a two-byte word address and then data bytes. For a read it returns bytes from a persistent word pointer. The block never drives SDA high. It pulls the line low through an open-drain enable, both for acknowledges and for the zero bits of read data.

The storage is modelled as a synchronous byte RAM. Each received data byte goes into the RAM on the cycle it is acknowledged. The stop that closes a write transaction holding at least one data byte starts a fixed-length busy interval, which stands for the internal programming cycle. While that interval runs, the block acknowledges nothing. A master finds out that the cycle has ended by repeating its address until it gets an acknowledge.

Top module: `twowire_mem_slave`

## Requirements
- R1: SDA is released (`sda_oe` = 0) after reset and while the bus is idle. `sda_oe` changes only while the synchronized SCL is low.
- R2: The first byte after a start is an address byte. Its upper seven bits must equal `{DEV_ID, strap}`, with DEV_ID = 4'b1010 by default, and bit 0 gives the direction (1 = read, 0 = write). On a match the slave acknowledges by holding SDA low during the ninth clock. On a mismatch it releases SDA and ignores every byte until the next start.
- R3: A write-direction address byte is followed by the high word-address byte, then the low word-address byte, then data bytes. Each data byte is stored at the pointer. A repeated start followed by a read-direction address byte then returns the stored byte from the address just loaded. All bytes travel most significant bit first.
- R4: A stop that ends a write transaction holding at least one data byte starts a busy interval of WR_CYCLES system clocks. During that interval the slave acknowledges no address byte. Once it ends, the slave acknowledges again.
- R5: After any access to address n, the pointer holds n+1. A read that starts with no word address returns the byte at that pointer.
- R6: In a sequential read, each master acknowledge advances the pointer. The pointer wraps from 2^ADDR_W-1 to 0.
- R7: During a write, the pointer advances only within the current aligned page of PAGE_BYTES bytes. A byte sent beyond the page end overwrites the start of the same page.
- R8: A start that arrives in the middle of a byte abandons that byte without storing it and re-arms address matching. The pointer keeps the value loaded before.
- R9: Word-address bits at and above ADDR_W are ignored. The address therefore aliases modulo 2^ADDR_W.
- R10: After the master does not acknowledge a read byte, the slave drives nothing more until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed (wired-AND level) |
| strap | input | 3 | Address strap pins, low three address bits |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |

## Verification
The assertions assume a real wired-AND bus. That means a start or stop edge cannot occur while the slave itself holds SDA low. They also assume that each SCL phase outlasts the synchronizer and edge-detect latency, so that every bus edge produces exactly one event. The stimulus keeps within these limits. It holds every SCL quarter period for five system clocks and changes SDA only with SCL low, except at intentional start and stop conditions. It feeds back to the block the AND of the master's drive and the slave's release.

// File: rtl/sms_pkg.sv
package sms_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_WAIT
  } sms_state_t;

  localparam int BYTE_W   = 8;
  localparam int ACK_SLOT = 8;
endpackage

// File: rtl/sms_sync.sv
module sms_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/sms_wtimer.sv
module sms_wtimer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (go)          left <= CW'(CYCLES);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign busy = (left != '0);

  // R4
  busy_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(go));
endmodule

// File: rtl/sms_ram.sv
module sms_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
  import sms_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter int         PAGE_BYTES  = 64,
  parameter int         WR_CYCLES   = 2000,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  output logic       sda_oe
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'(PAGE_BYTES - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_e, stop_e;
  logic busy, go;
  sms_state_t st, nxt;
  logic [3:0] cnt;
  logic [BYTE_W-1:0] sh, ahi, rdat;
  logic ackd, wrote;
  logic [ADDR_W-1:0] ptr, ptr_pg;
  logic mem_we, slot;

  sms_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(start_e), .bus_stop(stop_e)
  );

  sms_wtimer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .go(go), .busy(busy)
  );

  assign slot   = (cnt == 4'(ACK_SLOT));
  assign mem_we = scl_fall && slot && (st == ST_WDAT);
  assign go     = stop_e && wrote;
  assign ptr_pg = (ptr & ~PAGE_MASK) | ((ptr + 1'b1) & PAGE_MASK);

  sms_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
    .clk(clk), .we(mem_we), .waddr(ptr), .wdata(sh),
    .raddr(ptr), .rdata(rdat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; nxt <= ST_IDLE; cnt <= '0; sh <= '0; ahi <= '0;
      sda_oe <= 1'b0; ackd <= 1'b0; wrote <= 1'b0; ptr <= '0;
    end else if (start_e) begin
      st <= ST_DEV; cnt <= '0; sda_oe <= 1'b0; ackd <= 1'b0;
    end else if (stop_e) begin
      st <= ST_IDLE; cnt <= '0; sda_oe <= 1'b0; ackd <= 1'b0; wrote <= 1'b0;
    end else if (st != ST_IDLE && st != ST_WAIT) begin
      if (scl_rise) begin
        if (!slot) begin
          sh  <= {sh[BYTE_W-2:0], sda_s};
          cnt <= cnt + 4'd1;
        end else begin
          cnt <= '0;
          if (st == ST_RDAT) begin
            ptr <= ptr + 1'b1;
            if (sda_s) st <= ST_WAIT;
          end else if (!ackd) begin
            st <= ST_WAIT;
          end else begin
            st <= nxt;
          end
        end
      end else if (scl_fall) begin
        if (slot) begin
          sda_oe <= 1'b0;
          ackd   <= 1'b0;
          case (st)
            ST_DEV: if (sh[7:1] == {DEV_ID, strap} && !busy) begin
              ackd <= 1'b1; sda_oe <= 1'b1;
              nxt  <= sh[0] ? ST_RDAT : ST_AHI;
            end
            ST_AHI: begin
              ahi <= sh; ackd <= 1'b1; sda_oe <= 1'b1; nxt <= ST_ALO;
            end
            ST_ALO: begin
              ptr <= ADDR_W'({ahi, sh}); ackd <= 1'b1; sda_oe <= 1'b1;
              nxt <= ST_WDAT;
            end
            ST_WDAT: begin
              ptr <= ptr_pg; wrote <= 1'b1; ackd <= 1'b1; sda_oe <= 1'b1;
              nxt <= ST_WDAT;
            end
            default: ;
          endcase
        end else if (st == ST_RDAT) begin
          sda_oe <= ~rdat[3'd7 - cnt[2:0]];
        end else begin
          sda_oe <= 1'b0;
        end
      end
    end
  end

  // R1
  oe_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s));
  // R10
  wait_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> !sda_oe);
  // R4
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && st == ST_DEV) |-> !sda_oe);
  // R4
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !busy);
endmodule

// File: tb/twowire_mem_slave_test.sv
module twowire_mem_slave_test;
  localparam int Q = 5;
  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;
  localparam logic [23:0] VEC [5] = '{24'h01235A, 24'h07FEC3, 24'h004000,
                                     24'h07FF3C, 24'h000081};

  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  twowire_mem_slave #(.ADDR_W(11), .PAGE_BYTES(8), .WR_CYCLES(400)) uut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus),
    .strap(3'b101), .sda_oe(sda_oe)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    @(negedge clk) sda_m = b; qwait(Q);
    scl = 1'b1; qwait(2 * Q);
    scl = 1'b0; qwait(Q);
  endtask

  task automatic bit_in(output logic b);
    @(negedge clk) sda_m = 1'b1; qwait(Q);
    scl = 1'b1; qwait(Q); b = sda_bus; qwait(Q);
    scl = 1'b0; qwait(Q);
  endtask

  task automatic bus_start;
    @(negedge clk) sda_m = 1'b1; qwait(Q);
    scl = 1'b1; qwait(Q);
    sda_m = 1'b0; qwait(Q);
    scl = 1'b0; qwait(Q);
  endtask

  task automatic bus_stop;
    @(negedge clk) sda_m = 1'b0; qwait(Q);
    scl = 1'b1; qwait(Q);
    sda_m = 1'b1; qwait(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit_in(b[i]);
    bit_out(~mack);
  endtask

  task automatic wait_ready(output int polls);
    logic a = 1'b0;
    polls = 0;
    while (!a && polls < 40) begin
      bus_start; send_byte(DEV_W, a); bus_stop; polls++;
    end
  endtask

  task automatic write_run(input logic [15:0] adr, input logic [7:0] first,
                           input int n, input bit poll);
    logic a;
    int p;
    bus_start;
    send_byte(DEV_W, a); send_byte(adr[15:8], a); send_byte(adr[7:0], a);
    for (int i = 0; i < n; i++) send_byte(first + 8'(i), a);
    bus_stop;
    if (poll) wait_ready(p);
  endtask

  task automatic rd_at(input logic [15:0] adr, output logic [7:0] b);
    logic a;
    bus_start;
    send_byte(DEV_W, a); send_byte(adr[15:8], a); send_byte(adr[7:0], a);
    bus_start;
    send_byte(DEV_R, a);
    recv_byte(1'b0, b);
    bus_stop;
  endtask

  initial begin
    logic a;
    logic [7:0] d, d2;
    int p;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    qwait(4);
    check("R1 reset release", sda_oe, 1'b0);

    // R2: mismatch stays silent on later bytes, match acknowledges
    bus_start; send_byte(8'hA2, a); check("R2 mismatch addr", a, 1'b0);
    send_byte(8'h00, a); check("R2 ignored byte", a, 1'b0); bus_stop;
    bus_start; send_byte(DEV_W, a); check("R2 match ack", a, 1'b1); bus_stop;

    // R3: vector table of write then random read
    for (int i = 0; i < 5; i++) begin
      write_run(VEC[i][23:8], VEC[i][7:0], 1, 1'b1);
      rd_at(VEC[i][23:8], d);
      check("R3 readback", d, VEC[i][7:0]);
    end

    // R6: sequential read wraps top address to zero
    bus_start;
    send_byte(DEV_W, a); send_byte(8'h07, a); send_byte(8'hFF, a);
    bus_start; send_byte(DEV_R, a);
    recv_byte(1'b1, d); recv_byte(1'b0, d2); bus_stop;
    check("R6 top byte", d, 8'h3C);
    check("R6 wrapped byte", d2, 8'h81);

    // R9: upper word-address bits alias
    write_run(16'hF805, 8'h66, 1, 1'b1);
    rd_at(16'h0005, d);
    check("R9 alias", d, 8'h66);

    // R8: start inside a data byte aborts it, pointer stays
    bus_start;
    send_byte(DEV_W, a); send_byte(8'h00, a); send_byte(8'h05, a);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_start; send_byte(DEV_R, a);
    check("R8 rearmed", a, 1'b1);
    recv_byte(1'b0, d); bus_stop;
    check("R8 no partial write", d, 8'h66);

    // R4: busy after a write
    write_run(16'h0300, 8'h77, 1, 1'b0);
    bus_start; send_byte(DEV_W, a); bus_stop;
    check("R4 nack while busy", a, 1'b0);
    wait_ready(p);
    check("R4 ack after busy", (p < 40), 1'b1);
    rd_at(16'h0300, d);
    check("R4 data landed", d, 8'h77);

    // R7: page wrap, then R5 current-address read
    write_run(16'h0100, 8'h10, 9, 1'b1);
    bus_start; send_byte(DEV_R, a); recv_byte(1'b0, d); bus_stop;
    check("R5 current read", d, 8'h11);
    rd_at(16'h0100, d);
    check("R7 page start overwritten", d, 8'h18);
    rd_at(16'h0107, d);
    check("R7 page end", d, 8'h17);

    // R10: after master NACK the slave stays silent
    write_run(16'h01FF, 8'h00, 1, 1'b1);
    write_run(16'h0200, 8'h00, 1, 1'b1);
    bus_start;
    send_byte(DEV_W, a); send_byte(8'h01, a); send_byte(8'hFF, a);
    bus_start; send_byte(DEV_R, a);
    recv_byte(1'b0, d);
    recv_byte(1'b0, d2);
    bus_stop;
    check("R10 last byte", d, 8'h00);
    check("R10 silent after nack", d2, 8'hFF);
    check("R1 idle release", sda_oe, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule